// File: doc/BRIEF.md
# Sequential Modular Adder/Subtractor

This block computes the residue of a sum or a difference of two small unsigned operands with respect to a modulus supplied alongside them. A single request, started with a one-cycle `start_i` while the block is idle, yields either (x + y) mod p or (x − y) mod p. The `mode_i` input picks which one. Results are defined only for operands that already lie below the modulus.

The work is spread over several clock cycles. A small state machine reuses one two's-complement adder/subtractor, two bits wider than the operands, twice. In the first pass it forms the raw sum or difference. In the second pass it applies the modulus correction by subtracting or adding p. A rule that depends on the mode then decides whether the corrected or the raw value is the answer.

The operands, the modulus and the mode are latched when a request is accepted. The result is presented together with a one-cycle `done_o` pulse, and it stays on `t_o` until the next result replaces it.

Top module: `modular_addsub`

## Requirements
- R1: While `rst_i` is high (asynchronous, active high), the block is idle, `done_o` is 0 and `t_o` is 0.
- R2: With `mode_i` = 0 when the request is accepted, the result on `t_o` is (x + y) mod p for every 1 ≤ p ≤ 15 and 0 ≤ x, y < p.
- R3: With `mode_i` = 1 when the request is accepted, the result on `t_o` is (x − y) mod p, always in the range 0 to p−1, for every 1 ≤ p ≤ 15 and 0 ≤ x, y < p.
- R4: A request is accepted when `start_i` is high at a rising edge while the block is idle. `done_o` rises after the third rising edge counted from that edge, and the result is valid on `t_o` in that same cycle.
- R5: `done_o` is high for exactly one cycle per request. The block is idle again on the following cycle and accepts a new request at once.
- R6: Changes to `x_i`, `y_i`, `p_i`, `mode_i`, and a high `start_i`, while a request is in progress have no effect on its result.
- R7: `t_o` changes only in a cycle where `done_o` is high, and it holds that value until the next result.
- R8: While idle with `start_i` low, `done_o` stays 0 and `t_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | Request strobe, sampled only while idle |
| mode_i | input | 1 | 0 = modular addition, 1 = modular subtraction |
| x_i | input | 4 | First operand, below p |
| y_i | input | 4 | Second operand, below p |
| p_i | input | 4 | Modulus, 1 to 15 |
| t_o | output | 4 | Result, held between requests |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
On every cycle, the bound checker watches the state sequence from acceptance to `done_o`. It also checks that `done_o` never lasts two cycles, that `t_o` moves only when `done_o` is high, that the latched operands stay frozen while a request is in progress, and that every result is below the latched modulus. Only the bench scenarios can show that the residues themselves are correct. They do this by sweeping every legal operand and modulus triple in both modes against a remainder computed in the bench. The bench also covers inputs scrambled and `start_i` raised during a request, idling with no request, and reset asserted in the middle of a request.

// File: rtl/modular_addsub_pkg.sv
package modular_addsub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FIRST  = 3'd1,
        ST_REDUCE = 3'd2,
        ST_OUT_T1 = 3'd3,
        ST_OUT_T2 = 3'd4
    } mas_state_e;

endpackage

// File: rtl/mas_full_add.sv
module mas_full_add (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = a_i ^ b_i ^ c_i;
    assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/mas_addsub_unit.sv
// Ripple two's-complement adder/subtractor: b is inverted and the carry-in
// raised when sub_i is set.
module mas_addsub_unit #(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] b_x;
    logic [W-1:0] cy;

    assign b_x   = b_i ^ {W{sub_i}};
    assign cy[0] = sub_i;

    for (genvar i = 0; i < W - 1; i++) begin : g_cell
        mas_full_add u_fa (
            .a_i (a_i[i]),
            .b_i (b_x[i]),
            .c_i (cy[i]),
            .s_o (s_o[i]),
            .c_o (cy[i+1])
        );
    end

    // Sign position: carry out of the top bit is not needed
    assign s_o[W-1] = a_i[W-1] ^ b_x[W-1] ^ cy[W-1];
endmodule

// File: rtl/mas_pick.sv
// Chooses the corrected value: addition keeps t1 - p unless it went negative,
// subtraction keeps t1 unless it went negative.
module mas_pick (
    input  logic sub_mode_i,
    input  logic t1_neg_i,
    input  logic t2_neg_i,
    output logic take_t2_o
);
    assign take_t2_o = sub_mode_i ? t1_neg_i : ~t2_neg_i;
endmodule

// File: rtl/modular_addsub.sv
module modular_addsub
    import modular_addsub_pkg::*;
#(
    parameter int OPW = 4,
    parameter int EXT = 2
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           start_i,
    input  logic           mode_i,
    input  logic [OPW-1:0] x_i,
    input  logic [OPW-1:0] y_i,
    input  logic [OPW-1:0] p_i,
    output logic [OPW-1:0] t_o,
    output logic           done_o
);
    localparam int ACCW = OPW + EXT;

    typedef struct packed {
        mas_state_e      state;
        logic            mode;
        logic [OPW-1:0]  x;
        logic [OPW-1:0]  y;
        logic [OPW-1:0]  p;
        logic [ACCW-1:0] t1;
        logic [OPW-1:0]  res;
    } mas_regs_t;

    mas_regs_t r_d, r_q;

    logic [ACCW-1:0] op_a, op_b, op_s;
    logic            op_sub;
    logic            take_t2;

    // Operand steering for the shared unit
    always_comb begin
        if (r_q.state == ST_FIRST) begin
            op_a   = {{EXT{1'b0}}, r_q.x};
            op_b   = {{EXT{1'b0}}, r_q.y};
            op_sub = r_q.mode;
        end else begin
            op_a   = r_q.t1;
            op_b   = {{EXT{1'b0}}, r_q.p};
            op_sub = ~r_q.mode;
        end
    end

    mas_addsub_unit #(.W(ACCW)) u_unit (
        .a_i   (op_a),
        .b_i   (op_b),
        .sub_i (op_sub),
        .s_o   (op_s)
    );

    mas_pick u_pick (
        .sub_mode_i (r_q.mode),
        .t1_neg_i   (r_q.t1[ACCW-1]),
        .t2_neg_i   (op_s[ACCW-1]),
        .take_t2_o  (take_t2)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.mode  = mode_i;
                    r_d.x     = x_i;
                    r_d.y     = y_i;
                    r_d.p     = p_i;
                    r_d.state = ST_FIRST;
                end
            end
            ST_FIRST: begin
                r_d.t1    = op_s;
                r_d.state = ST_REDUCE;
            end
            ST_REDUCE: begin
                if (take_t2) begin
                    r_d.res   = op_s[OPW-1:0];
                    r_d.state = ST_OUT_T2;
                end else begin
                    r_d.res   = r_q.t1[OPW-1:0];
                    r_d.state = ST_OUT_T1;
                end
            end
            ST_OUT_T1, ST_OUT_T2: r_d.state = ST_IDLE;
            default:              r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign t_o    = r_q.res;
    assign done_o = (r_q.state == ST_OUT_T1) || (r_q.state == ST_OUT_T2);
endmodule

// File: rtl/mas_checker.sv
module mas_checker
    import modular_addsub_pkg::*;
#(
    parameter int OPW = 4
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           start_i,
    input logic           done_o,
    input logic [OPW-1:0] t_o,
    input mas_state_e     state,
    input logic           mode_q,
    input logic [OPW-1:0] x_q,
    input logic [OPW-1:0] y_q,
    input logic [OPW-1:0] p_q
);
    AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_IDLE && start_i) |=> (state == ST_FIRST)); // R4
    AST_FIRST_THEN_REDUCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_FIRST) |=> (state == ST_REDUCE)); // R4
    AST_REDUCE_THEN_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_REDUCE) |=> done_o); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!done_o && state == ST_IDLE)); // R5
    AST_T_MOVES_ON_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(t_o) |-> done_o); // R7
    AST_OPERANDS_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (state != ST_IDLE) |=> ($stable(x_q) && $stable(y_q) && $stable(p_q) && $stable(mode_q))); // R6
    AST_RESULT_BELOW_P: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (t_o < p_q)); // R2
endmodule

bind modular_addsub mas_checker #(.OPW(OPW)) u_mas_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .done_o  (done_o),
    .t_o     (t_o),
    .state   (r_q.state),
    .mode_q  (r_q.mode),
    .x_q     (r_q.x),
    .y_q     (r_q.y),
    .p_q     (r_q.p)
);

// File: tb/test_modular_addsub.sv
`timescale 1ns/1ps
module test_modular_addsub;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] x = '0, y = '0, p = '0;
    logic [3:0] t;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    modular_addsub i_modular_addsub (
        .clk_i (clk), .rst_i (rst), .start_i (start), .mode_i (mode),
        .x_i (x), .y_i (y), .p_i (p), .t_o (t), .done_o (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_res(input bit m, input int xv, input int yv, input int pv);
        if (!m) return (xv + yv) % pv;
        return ((xv - yv) % pv + pv) % pv;
    endfunction

    // One request; disturb scrambles inputs and raises start while busy
    task automatic run_one(input bit m, input int xv, input int yv, input int pv, input bit disturb);
        int lat;
        int got;
        @(negedge clk);
        mode = m; x = 4'(xv); y = 4'(yv); p = 4'(pv); start = 1'b1;
        @(negedge clk);
        lat = 1;
        start = disturb;
        if (disturb) begin
            mode = ~m; x = ~x; y = ~y; p = ~p;
        end
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (disturb) begin
                x = x + 4'd3; p = p + 4'd5;
            end
        end
        got = int'(t);
        check(lat == 3, "R4 latency", lat, 3);
        if (!m) check(got == ref_res(m, xv, yv, pv), disturb ? "R6 add" : "R2 add", got, ref_res(m, xv, yv, pv));
        else    check(got == ref_res(m, xv, yv, pv), disturb ? "R6 sub" : "R3 sub", got, ref_res(m, xv, yv, pv));
        @(negedge clk);
        check(done == 1'b0, "R5 done width", int'(done), 0);
        check(int'(t) == got, "R7 hold", int'(t), got);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        check(t == 4'd0, "R1 t in reset", int'(t), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sweep(input bit m);
        for (int pv = 1; pv < 16; pv++)
            for (int xv = 0; xv < pv; xv++)
                for (int yv = 0; yv < pv; yv++)
                    run_one(m, xv, yv, pv, 1'b0);
    endtask

    task automatic t_disturb;
        run_one(1'b0, 6, 7, 11, 1'b1);
        run_one(1'b1, 2, 9, 13, 1'b1);
        run_one(1'b1, 14, 0, 15, 1'b1);
        run_one(1'b0, 0, 0, 1, 1'b1);
    endtask

    task automatic t_idle;
        logic [3:0] keep;
        run_one(1'b0, 4, 5, 7, 1'b0);
        keep = t;
        x = 4'd1; y = 4'd1; p = 4'd3; mode = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R8 idle done", int'(done), 0);
            check(t == keep, "R8 idle t", int'(t), int'(keep));
        end
    endtask

    task automatic t_midreset;
        @(negedge clk);
        mode = 1'b0; x = 4'd5; y = 4'd6; p = 4'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1 rst = 1'b1;
        #0.5;
        check(done == 1'b0, "R1 async done", int'(done), 0);
        check(t == 4'd0, "R1 async t", int'(t), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R1 held done", int'(done), 0);
        end
        rst = 1'b0;
        run_one(1'b1, 3, 8, 10, 1'b0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #5;
        t_reset();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_disturb();
        t_idle();
        t_midreset();
        summary();
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule